// File: doc/BRIEF.md
# Instruction Stream Byte Parser

This block turns a byte-wide instruction stream into one assembled instruction at a time. The stream arrives one byte per accepted handshake. Each instruction starts with a 16-bit control word, least-significant byte first. The parser splits the control word into its fields and uses the opcode to decide whether a source operand, a target operand, both or neither follow. It then collects the operand bytes. The number of bytes in each operand depends on the operand type and on the operation size.

When the last byte of an instruction has been accepted, the parser shows the decoded fields and the operand values. Operand values are little-endian and zero-extended to 32 bits. It also shows the total instruction length and pulses instr-valid for one cycle. A malformed control word pulses instr-invalid instead. In both cases the input stays stalled until the consumer returns a done strobe.

A condition-pass output combines the held condition code with the live zero and carry flag inputs. The consumer can therefore decide whether to execute the instruction without decoding the condition itself.

Top module: `instr_parser`

## Requirements
- R1: After reset, byte_ready_o is 1 and instr_valid_o and instr_invalid_o are 0.
- R2: The first accepted byte is control-word bits 7:0 and the second is bits 15:8. Within the control word, source type is bits 1:0, target type bits 3:2, condition bits 6:4, reserved bit 7, opcode bits 13:8 and size bits 15:14. These fields appear on src_type_o, tgt_type_o, cond_o, opcode_o and size_o.
- R3: An operand of type 0 (register) or type 1 (register pointer) is one byte. Type 3 (immediate pointer) is four bytes. Type 2 (immediate) is one, two or four bytes for size 0, 1 or 2.
- R4: The source operand bytes come before the target operand bytes. Each operand is little-endian and is zero-extended to 32 bits on src_val_o and tgt_val_o.
- R5: Opcodes 0x00, 0x0C, 0x0D, 0x10, 0x1C, 0x1D, 0x20, 0x2A and 0x3A take no operands. Opcodes 0x08, 0x09, 0x0A, 0x11, 0x18, 0x19, 0x1A, 0x28, 0x29, 0x2C, 0x2D, 0x31, 0x33 and 0x3D take a source operand only. Opcodes 0x01-0x07, 0x0B, 0x13-0x17, 0x1B, 0x21-0x27, 0x32, 0x34, 0x35 and 0x39 take both operands.
- R6: instr_valid_o is high for exactly the one cycle after the clock edge that accepts the last byte of the instruction. At that point length_o holds the total byte count, control word included.
- R7: From the cycle after the last byte until the cycle after done_i is sampled high, byte_ready_o is 0 and no byte is consumed. done_i has no effect while an instruction is still being collected.
- R8: The control word is malformed if bit 7 is 1, the size is 3, the condition is 7 or the opcode is not listed in R5. In that case instr_invalid_o pulses for one cycle after the second control byte, no operand bytes are consumed, and length_o is 2.
- R9: cond_pass_o is 1 for these conditions: 0 always; 1 when zero_i is set; 2 when zero_i is clear; 3 when carry_i is set; 4 when carry_i is clear; 5 when both are clear; 6 when either is set. It is 0 for condition 7.
- R10: Cycles with byte_valid_i low do not advance the parse, and byte_ready_o stays 1 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte present |
| byte_ready_o | output | 1 | Parser takes a byte this cycle |
| done_i | input | 1 | Consumer finished with held instruction |
| zero_i | input | 1 | Zero flag |
| carry_i | input | 1 | Carry flag |
| instr_valid_o | output | 1 | One-cycle pulse: instruction complete |
| instr_invalid_o | output | 1 | One-cycle pulse: malformed control word |
| opcode_o | output | 6 | Opcode field |
| size_o | output | 2 | Size field |
| cond_o | output | 3 | Condition field |
| src_type_o | output | 2 | Source operand type |
| tgt_type_o | output | 2 | Target operand type |
| src_val_o | output | 32 | Source operand, zero-extended |
| tgt_val_o | output | 32 | Target operand, zero-extended |
| length_o | output | 4 | Total instruction bytes |
| cond_pass_o | output | 1 | Condition satisfied by current flags |

## Verification
The hardest situations to reach from the ports are stream bytes that arrive while an instruction is held, and a done strobe that arrives in the middle of collecting an instruction. Both must leave the byte count unchanged. The bench keeps byte_valid_i high with a junk byte throughout every hold and the cycle that carries done_i. It also asserts done_i on every byte of some instructions. The instruction that follows must then decode exactly as the reference model predicts, so any consumed or skipped byte shows up as wrong fields or values.

// File: rtl/instr_pkg.sv
package instr_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SRC   = 2'd1,
    CLS_BOTH  = 2'd2,
    CLS_UNDEF = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    ST_CW_LO = 3'd0,
    ST_CW_HI = 3'd1,
    ST_SRC   = 3'd2,
    ST_TGT   = 3'd3,
    ST_HOLD  = 3'd4
  } parse_st_e;

  function automatic op_class_e op_class(input logic [5:0] op);
    unique case (op)
      6'h00, 6'h0C, 6'h0D, 6'h10, 6'h1C, 6'h1D, 6'h20, 6'h2A, 6'h3A:
        op_class = CLS_NONE;
      6'h08, 6'h09, 6'h0A, 6'h11, 6'h18, 6'h19, 6'h1A, 6'h28, 6'h29,
      6'h2C, 6'h2D, 6'h31, 6'h33, 6'h3D:
        op_class = CLS_SRC;
      6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0B,
      6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h1B,
      6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
      6'h32, 6'h34, 6'h35, 6'h39:
        op_class = CLS_BOTH;
      default:
        op_class = CLS_UNDEF;
    endcase
  endfunction

  // operand byte count from type and size
  function automatic logic [2:0] opnd_bytes(input logic [1:0] kind, input logic [1:0] sz);
    unique case (kind)
      2'd2:    opnd_bytes = (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
      2'd3:    opnd_bytes = 3'd4;
      default: opnd_bytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/instr_cw_decode.sv
module instr_cw_decode
  import instr_pkg::*;
(
  input  logic [15:0] cw_i,
  output op_class_e   cls_o,
  output logic [2:0]  src_len_o,
  output logic [2:0]  tgt_len_o,
  output logic [3:0]  total_len_o,
  output logic        bad_o
);
  logic [2:0] src_part, tgt_part;

  always_comb begin
    cls_o     = op_class(cw_i[13:8]);
    src_len_o = opnd_bytes(cw_i[1:0], cw_i[15:14]);
    tgt_len_o = opnd_bytes(cw_i[3:2], cw_i[15:14]);
    bad_o     = cw_i[7] | (cw_i[15:14] == 2'd3) | (cw_i[6:4] == 3'd7) | (cls_o == CLS_UNDEF);
    src_part  = (cls_o == CLS_SRC || cls_o == CLS_BOTH) ? src_len_o : 3'd0;
    tgt_part  = (cls_o == CLS_BOTH) ? tgt_len_o : 3'd0;
    total_len_o = 4'd2 + {1'b0, src_part} + {1'b0, tgt_part};
  end
endmodule

// File: rtl/instr_opnd_reg.sv
module instr_opnd_reg #(
  parameter int OPND_W = 32,
  localparam int NBYTES = OPND_W / 8,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  output logic [OPND_W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= '0;
    else if (clr_i) val_o <= '0;
    else if (wr_i)  val_o[idx_i*8 +: 8] <= byte_i;
  end
endmodule

// File: rtl/instr_cond_eval.sv
module instr_cond_eval (
  input  logic [2:0] cond_i,
  input  logic       zero_i,
  input  logic       carry_i,
  output logic       pass_o
);
  always_comb begin
    unique case (cond_i)
      3'd0:    pass_o = 1'b1;
      3'd1:    pass_o = zero_i;
      3'd2:    pass_o = ~zero_i;
      3'd3:    pass_o = carry_i;
      3'd4:    pass_o = ~carry_i;
      3'd5:    pass_o = ~zero_i & ~carry_i;
      3'd6:    pass_o = zero_i | carry_i;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/instr_parser.sv
module instr_parser
  import instr_pkg::*;
#(
  parameter int OPND_W = 32,
  localparam int NBYTES = OPND_W / 8,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic              done_i,
  input  logic              zero_i,
  input  logic              carry_i,
  output logic              instr_valid_o,
  output logic              instr_invalid_o,
  output logic [5:0]        opcode_o,
  output logic [1:0]        size_o,
  output logic [2:0]        cond_o,
  output logic [1:0]        src_type_o,
  output logic [1:0]        tgt_type_o,
  output logic [OPND_W-1:0] src_val_o,
  output logic [OPND_W-1:0] tgt_val_o,
  output logic [3:0]        length_o,
  output logic              cond_pass_o
);
  parse_st_e        state_q;
  logic [15:0]      cw_q;
  logic [IDX_W-1:0] cnt_q;
  logic [3:0]       len_q;
  logic             vld_q, inv_q;

  logic [15:0] dec_cw;
  op_class_e   cls;
  logic [2:0]  src_len, tgt_len, cur_len;
  logic [3:0]  total_len;
  logic        bad, accept, last_byte, clr_opnd;
  logic [1:0]  opnd_wr;
  logic [OPND_W-1:0] opnd_val [2];

  // during the high control byte, decode from the incoming byte directly
  assign dec_cw = (state_q == ST_CW_HI) ? {byte_i, cw_q[7:0]} : cw_q;

  instr_cw_decode u_dec (
    .cw_i        (dec_cw),
    .cls_o       (cls),
    .src_len_o   (src_len),
    .tgt_len_o   (tgt_len),
    .total_len_o (total_len),
    .bad_o       (bad)
  );

  assign byte_ready_o = (state_q != ST_HOLD);
  assign accept       = byte_valid_i & byte_ready_o;
  assign cur_len      = (state_q == ST_TGT) ? tgt_len : src_len;
  assign last_byte    = ({{(3-IDX_W){1'b0}}, cnt_q} == cur_len - 3'd1);
  assign clr_opnd     = accept & (state_q == ST_CW_HI);
  assign opnd_wr[0]   = accept & (state_q == ST_SRC);
  assign opnd_wr[1]   = accept & (state_q == ST_TGT);

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    instr_opnd_reg #(.OPND_W(OPND_W)) u_opnd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_opnd),
      .wr_i   (opnd_wr[g]),
      .idx_i  (cnt_q),
      .byte_i (byte_i),
      .val_o  (opnd_val[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CW_LO;
      cw_q    <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      vld_q   <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      inv_q <= 1'b0;
      unique case (state_q)
        ST_CW_LO: if (accept) begin
          cw_q[7:0] <= byte_i;
          state_q   <= ST_CW_HI;
        end
        ST_CW_HI: if (accept) begin
          cw_q[15:8] <= byte_i;
          cnt_q      <= '0;
          len_q      <= bad ? 4'd2 : total_len;
          if (bad) begin
            inv_q   <= 1'b1;
            state_q <= ST_HOLD;
          end else if (cls == CLS_NONE) begin
            vld_q   <= 1'b1;
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_SRC;
          end
        end
        ST_SRC, ST_TGT: if (accept) begin
          if (last_byte) begin
            cnt_q <= '0;
            if (state_q == ST_SRC && cls == CLS_BOTH) begin
              state_q <= ST_TGT;
            end else begin
              vld_q   <= 1'b1;
              state_q <= ST_HOLD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: if (done_i) state_q <= ST_CW_LO;
        default: state_q <= ST_CW_LO;
      endcase
    end
  end

  instr_cond_eval u_cond (
    .cond_i  (cw_q[6:4]),
    .zero_i  (zero_i),
    .carry_i (carry_i),
    .pass_o  (cond_pass_o)
  );

  assign instr_valid_o   = vld_q;
  assign instr_invalid_o = inv_q;
  assign opcode_o        = cw_q[13:8];
  assign size_o          = cw_q[15:14];
  assign cond_o          = cw_q[6:4];
  assign src_type_o      = cw_q[1:0];
  assign tgt_type_o      = cw_q[3:2];
  assign src_val_o       = opnd_val[0];
  assign tgt_val_o       = opnd_val[1];
  assign length_o        = len_q;

  // R6
  valid_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |=> !instr_valid_o);
  // R6
  valid_invalid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_valid_o && instr_invalid_o));
  // R7
  hold_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o || instr_invalid_o) |-> !byte_ready_o);
  // R7
  stall_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_ready_o && !done_i) |=> !byte_ready_o);
  // R8
  invalid_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_invalid_o |-> (length_o == 4'd2));
  // R3
  valid_len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> (length_o >= 4'd2 && length_o <= 4'd10));
  // R9
  cond_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o == 3'd7) |-> !cond_pass_o);
endmodule

// File: tb/tb_instr_parser.sv
`timescale 1ns/1ps
module tb_instr_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic        done = 1'b0;
  logic        zf = 1'b0, cf = 1'b0;
  logic        ivalid, iinvalid, cpass;
  logic [5:0]  opcode;
  logic [1:0]  size, stype, ttype;
  logic [2:0]  cond;
  logic [31:0] sval, tval;
  logic [3:0]  len;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  instr_parser dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .byte_valid_i(byte_valid),
    .byte_ready_o(byte_ready), .done_i(done), .zero_i(zf), .carry_i(cf),
    .instr_valid_o(ivalid), .instr_invalid_o(iinvalid), .opcode_o(opcode),
    .size_o(size), .cond_o(cond), .src_type_o(stype), .tgt_type_o(ttype),
    .src_val_o(sval), .tgt_val_o(tval), .length_o(len), .cond_pass_o(cpass)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: operand count per opcode (0 none, 1 src, 2 both, 3 undefined)
  function automatic int ref_class(input int op);
    if (op inside {'h00, 'h0C, 'h0D, 'h10, 'h1C, 'h1D, 'h20, 'h2A, 'h3A}) return 0;
    if (op inside {'h08, 'h09, 'h0A, 'h11, 'h18, 'h19, 'h1A, 'h28, 'h29, 'h2C, 'h2D, 'h31, 'h33, 'h3D}) return 1;
    if (op inside {['h01:'h07], 'h0B, ['h13:'h17], 'h1B, ['h21:'h27], 'h32, 'h34, 'h35, 'h39}) return 2;
    return 3;
  endfunction

  function automatic int ref_bytes(input int kind, input int sz);
    if (kind == 3) return 4;
    if (kind == 2) return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    return 1;
  endfunction

  function automatic bit ref_pass(input int c, input bit z, input bit k);
    case (c)
      0: return 1;
      1: return z;
      2: return !z;
      3: return k;
      4: return !k;
      5: return !z && !k;
      6: return z || k;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] mkcw(input int op, input int sz, input int c, input int st, input int tt);
    return 16'((sz << 14) | (op << 8) | (c << 4) | (tt << 2) | st);
  endfunction

  // drive one instruction, compare cycle by cycle against the model
  task automatic send(input logic [15:0] cw, input logic [31:0] sv, input logic [31:0] tv,
                      input int max_gap, input bit done_mid);
    logic [7:0] q[$];
    int cls, ls, lt, exp_len;
    bit bad;
    logic [31:0] es, et;
    cls = ref_class(int'(cw[13:8]));
    bad = cw[7] || cw[15:14] == 2'd3 || cw[6:4] == 3'd7 || cls == 3;
    ls = ref_bytes(int'(cw[1:0]), int'(cw[15:14]));
    lt = ref_bytes(int'(cw[3:2]), int'(cw[15:14]));
    es = '0;
    et = '0;
    q.push_back(cw[7:0]);
    q.push_back(cw[15:8]);
    if (!bad && cls >= 1)
      for (int k = 0; k < ls; k++) begin q.push_back(sv[8*k +: 8]); es[8*k +: 8] = sv[8*k +: 8]; end
    if (!bad && cls == 2)
      for (int k = 0; k < lt; k++) begin q.push_back(tv[8*k +: 8]); et[8*k +: 8] = tv[8*k +: 8]; end
    exp_len = q.size();
    foreach (q[i]) begin
      int gap;
      gap = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        byte_valid = 1'b0; byte_in = 8'hA5; done = done_mid;
        chk(byte_ready === 1'b1, "R10 ready while idle", 64'(byte_ready), 1);
        chk(ivalid === 1'b0, "R10 no pulse while idle", 64'(ivalid), 0);
      end
      @(negedge clk);
      byte_valid = 1'b1; byte_in = q[i]; done = done_mid;
      chk(byte_ready === 1'b1, "R7 ready while collecting", 64'(byte_ready), 1);
      chk(ivalid === 1'b0 && iinvalid === 1'b0, "R6 no early pulse", 64'({ivalid, iinvalid}), 0);
    end
    // cycle after last byte: results, junk byte offered during hold
    @(negedge clk);
    byte_in = 8'hEE; byte_valid = 1'b1; done = 1'b0;
    chk(ivalid === !bad, bad ? "R8 no valid on malformed" : "R6 valid pulse", 64'(ivalid), 64'(!bad));
    chk(iinvalid === bad, "R8 invalid pulse", 64'(iinvalid), 64'(bad));
    chk(byte_ready === 1'b0, "R7 ready low in hold", 64'(byte_ready), 0);
    chk(len === 4'(exp_len), bad ? "R8 length" : "R6 length", 64'(len), 64'(exp_len));
    chk({size, opcode, cond, ttype, stype} === {cw[15:8], cw[6:0]}, "R2 fields",
        64'({size, opcode, cond, ttype, stype}), 64'({cw[15:8], cw[6:0]}));
    if (!bad) begin
      chk(sval === es, "R4 source value", 64'(sval), 64'(es));
      chk(tval === et, "R4 target value", 64'(tval), 64'(et));
    end
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      zf = f[0]; cf = f[1];
      #0.5;
      chk(cpass === ref_pass(int'(cw[6:4]), zf, cf), "R9 cond pass", 64'(cpass),
          64'(ref_pass(int'(cw[6:4]), zf, cf)));
      chk(ivalid === 1'b0 && byte_ready === 1'b0, "R7 held stall", 64'({ivalid, byte_ready}), 0);
    end
    @(negedge clk);
    done = 1'b1;
    chk(byte_ready === 1'b0, "R7 ready low before done", 64'(byte_ready), 0);
    @(negedge clk);
    done = 1'b0; byte_valid = 1'b0;
    chk(byte_ready === 1'b1, "R7 ready after done", 64'(byte_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] ops[$] = '{6'h00, 6'h01, 6'h02, 6'h07, 6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h10,
                           6'h11, 6'h13, 6'h17, 6'h1A, 6'h1B, 6'h21, 6'h26, 6'h27, 6'h2A, 6'h2C,
                           6'h2D, 6'h31, 6'h33, 6'h35, 6'h39, 6'h3A, 6'h3D};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(byte_ready === 1'b1, "R1 reset ready", 64'(byte_ready), 1);
    chk(ivalid === 1'b0 && iinvalid === 1'b0, "R1 reset pulses", 64'({ivalid, iinvalid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(mkcw('h00, 0, 0, 0, 0), 0, 0, 0, 0);                    // R5 no operands
    send(mkcw('h08, 2, 1, 2, 0), 32'hDEADBEEF, 0, 2, 0);         // R5 source only, R3 imm32
    send(mkcw('h01, 0, 2, 0, 1), 32'h0000_0005, 32'h1F, 1, 0);   // R3 register bytes
    send(mkcw('h17, 1, 3, 2, 1), 32'h1234_ABCD, 32'h07, 0, 0);   // R3 imm16
    send(mkcw('h07, 0, 4, 2, 3), 32'hFFFF_FF12, 32'h89AB_CDEF, 1, 1); // R4 zero-extend, R7 done ignored
    send(mkcw('h0A, 0, 5, 3, 0), 32'h0403_0201, 0, 0, 0);        // R3 imm pointer always 4
    send(mkcw('h39, 2, 6, 2, 2), 32'h1111_2222, 32'h3333_4444, 3, 1);
    // R8 malformed control words, next instruction proves nothing consumed
    send(16'h0080, 0, 0, 0, 0);
    send(mkcw('h01, 3, 0, 0, 0), 0, 0, 0, 0);
    send(mkcw('h01, 0, 7, 0, 0), 0, 0, 0, 0);
    send(mkcw('h0E, 0, 0, 0, 0), 0, 0, 0, 0);
    send(mkcw('h13, 2, 0, 3, 2), 32'hCAFE_F00D, 32'h0BAD_0BAD, 1, 0);

    for (int n = 0; n < 40; n++) begin
      int op_i;
      op_i = int'($urandom_range(ops.size() - 1, 0));
      send(mkcw(int'(ops[op_i]), int'($urandom_range(2, 0)), int'($urandom_range(6, 0)),
                int'($urandom_range(3, 0)), int'($urandom_range(3, 0))),
           $urandom, $urandom, 2, n[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule